// File: doc/BRIEF.md
# Column-Scanning Wide Integer Multiplier

This block multiplies two unsigned integers of `N` words of `W` bits each and delivers the full `2N`-word product. It uses one `W`×`W` word multiplier and one wide accumulator. The partial products are grouped by output column: for column `k` it adds up every word product `a[i]·b[j]` with `i + j = k`. When a column is complete, the low word of the accumulator becomes result word `k` and the accumulator shifts right by one word. The leftover high bits then act as the carry into the next column. Because of this, each result word is written exactly once and no carry is stored back into the result.

A user presents both operands as flat vectors and pulses `start` while the block is idle. The operands are captured on that clock edge. The block then walks through columns `0` to `2N−2`, one word product per cycle, plus one extra cycle per column to emit that column's word. When the last column is emitted, the residue left in the accumulator is written as the top word. `done` then pulses for one cycle, and `product` holds the result until the next accepted start.

Top module: `comba_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is all zeros.
- R2: When `done` is high, `product` equals the full unsigned product `op_a × op_b` of the operands captured at the accepted start. This covers both words of every column, including the top word `2N−1`, which comes from the final residue.
- R3: `done` rises exactly `N·N + 2N − 1` clock edges after the edge that accepted `start`: one edge per word product plus one per column emit. For N=4 this is 23.
- R4: `done` is high for exactly one cycle. `busy` is high from the edge after an accepted start until the edge on which `done` rises, and `busy` is low while `done` is high.
- R5: A `start` pulse while `busy` is high is ignored. It does not change the latency or the result of the multiplication in progress.
- R6: Changes on `op_a`/`op_b` after the accepted start have no effect on the result. `product` keeps its value after `done` until the next accepted start.
- R7: Corner operands are exact. Zero times any value gives 0. All-ones times all-ones gives a top word of all ones and a lowest word of 1, with the words between following (2^(NW)−1)².
- R8: The accumulator never overflows its `2W + clog2(N) + 1` bits, and after the final column everything above bit `2W` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start request; accepted only while not busy |
| op_a | input | N*W | Multiplicand; word i sits at bits [i*W +: W] |
| op_b | input | N*W | Multiplier; word j sits at bits [j*W +: W] |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse: product is complete |
| product | output | 2*N*W | Result; word k sits at bits [k*W +: W] |

## Verification
The only timed result is `done`. It is due exactly 23 edges after the accepting edge (for N=4, W=16), and `product` must be valid in that same cycle. `busy` is due one edge after acceptance. The bench samples on falling edges and counts edges from the accepting edge. It checks that `done` does not arrive early, that it arrives exactly at the count, and that it is gone one edge later with `product` unchanged. The expected products are wide native multiplications computed in the bench. The sweep covers zero, all-ones, walking single words and pseudo-random operands, with restarts and operand changes injected mid-run.

// File: rtl/comba_pkg.sv
// Package comba_pkg
// Shared types for the column-scanning multiplier.
// Assumes: nothing beyond a standard SystemVerilog elaborator.
package comba_pkg;

    // Phases of the column sequencer.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MUL  = 2'd1,
        PH_EMIT = 2'd2
    } phase_t;

endpackage

// File: rtl/comba_opbank.sv
// Module comba_opbank
// Word-addressed operand store. It captures a flat N*W operand on load
// and returns one word per cycle, selected by rd_idx.
// Assumes: rd_idx < N while it is used; load only while the block is idle.
module comba_opbank #(
    parameter int N = 4,
    parameter int W = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [N*W-1:0] din,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_word
);

    logic [W-1:0] mem_q [N];

    // Capture every operand word on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) mem_q[k] <= '0;
        end else if (load) begin
            for (int k = 0; k < N; k++) mem_q[k] <= din[k*W +: W];
        end
    end

    // Combinational word read.
    always_comb rd_word = mem_q[rd_idx];

endmodule

// File: rtl/comba_sched.sv
// Module comba_sched
// Column sequencer. For each column k in 0..2N-2 it walks i from
// max(0,k-N+1) to min(k,N-1), with j = k-i, one word product per cycle.
// After that it spends one emit cycle on the column.
// Assumes: go is only raised while busy is low.
module comba_sched
    import comba_pkg::*;
#(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1,
    localparam int CW = $clog2(2 * N) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    output logic          busy,
    output logic          mul_en,
    output logic          emit_en,
    output logic          last_col,
    output logic [CW-1:0] col,
    output logic [IW-1:0] idx_a,
    output logic [IW-1:0] idx_b
);

    localparam logic [CW-1:0] NM1     = CW'(N - 1);
    localparam logic [CW-1:0] LASTCOL = CW'(2 * N - 2);

    phase_t        ph_q;
    logic [CW-1:0] col_q;
    logic [CW-1:0] i_q;
    logic [CW-1:0] i_hi;
    logic [CW-1:0] col_nx;
    logic [CW-1:0] lo_nx;
    logic          pair_last;

    // Pair bounds for the current column and the start of the next one.
    always_comb begin
        col_nx    = col_q + CW'(1);
        lo_nx     = (col_nx > NM1) ? (col_nx - NM1) : '0;
        i_hi      = (col_q > NM1) ? NM1 : col_q;
        pair_last = (i_q == i_hi);
    end

    // Phase, column and pair-index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            col_q <= '0;
            i_q   <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (go) begin
                        ph_q  <= PH_MUL;
                        col_q <= '0;
                        i_q   <= '0;
                    end
                end
                PH_MUL: begin
                    i_q <= i_q + CW'(1);
                    if (pair_last) ph_q <= PH_EMIT;
                end
                PH_EMIT: begin
                    if (col_q == LASTCOL) begin
                        ph_q <= PH_IDLE;
                    end else begin
                        ph_q  <= PH_MUL;
                        col_q <= col_nx;
                        i_q   <= lo_nx;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // Decoded outputs.
    always_comb begin
        busy     = (ph_q != PH_IDLE);
        mul_en   = (ph_q == PH_MUL);
        emit_en  = (ph_q == PH_EMIT);
        last_col = (col_q == LASTCOL);
        col      = col_q;
        idx_a    = IW'(i_q);
        idx_b    = IW'(col_q - i_q);
    end

    // R2: every scheduled pair lies inside both operands and on the column.
    assert_pair_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mul_en |-> (i_q <= i_hi) && ((col_q - i_q) < CW'(N)));

    // R3: the column index never runs past the last column.
    assert_col_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        col_q <= LASTCOL);

endmodule

// File: rtl/comba_mac.sv
// Module comba_mac
// Word multiplier feeding a column accumulator of 2W+clog2(N)+1 bits.
// It clears, adds one word product, or shifts right one word (emit).
// Assumes: clr, mul_en and shift_en are mutually exclusive.
module comba_mac #(
    parameter int N = 4,
    parameter int W = 16,
    localparam int LGN  = (N > 1) ? $clog2(N) : 0,
    localparam int ACCW = 2 * W + LGN + 1,
    localparam int XW   = ACCW - 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          mul_en,
    input  logic          shift_en,
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    output logic [W-1:0]  lo_word,
    output logic [W-1:0]  hi_word,
    output logic [XW-1:0] excess
);

    logic [ACCW-1:0] acc_q;
    logic [2*W-1:0]  prod;

    // Single word multiplier.
    always_comb prod = op_a * op_b;

    // Accumulate a product, or shift the finished column's word out.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
        end else if (mul_en) begin
            acc_q <= acc_q + ACCW'(prod);
        end else if (shift_en) begin
            acc_q <= acc_q >> W;
        end
    end

    // Word views of the accumulator.
    always_comb begin
        lo_word = acc_q[W-1:0];
        hi_word = acc_q[2*W-1:W];
        excess  = acc_q[ACCW-1:2*W];
    end

    // R8: the guard bit on top of the accumulator is never reached.
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_q[ACCW-1]);

endmodule

// File: rtl/comba_mul.sv
// Module comba_mul
// Top level of the column-scanning multiplier. It captures the operands on
// an accepted start, runs the column sequence through one multiplier, and
// writes each result word once. The top word comes from the final residue.
// Assumes: operands are unsigned; start is ignored while busy.
module comba_mul
    import comba_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 16,
    localparam int IW  = (N > 1) ? $clog2(N) : 1,
    localparam int CW  = $clog2(2 * N) + 1,
    localparam int LGN = (N > 1) ? $clog2(N) : 0,
    localparam int XW  = LGN + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [N*W-1:0]   op_a,
    input  logic [N*W-1:0]   op_b,
    output logic             busy,
    output logic             done,
    output logic [2*N*W-1:0] product
);

    logic          accept;
    logic          mul_en;
    logic          emit_en;
    logic          last_col;
    logic [CW-1:0] col;
    logic [IW-1:0] idx_a;
    logic [IW-1:0] idx_b;
    logic [W-1:0]  word_a;
    logic [W-1:0]  word_b;
    logic [W-1:0]  lo_word;
    logic [W-1:0]  hi_word;
    logic [XW-1:0] excess;
    logic          done_q;
    logic [2*N*W-1:0] res_q;

    // Start is taken only while idle.
    always_comb accept = start && !busy;

    comba_sched #(.N(N)) u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (accept),
        .busy     (busy),
        .mul_en   (mul_en),
        .emit_en  (emit_en),
        .last_col (last_col),
        .col      (col),
        .idx_a    (idx_a),
        .idx_b    (idx_b)
    );

    comba_opbank #(.N(N), .W(W)) u_bank_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .din     (op_a),
        .rd_idx  (idx_a),
        .rd_word (word_a)
    );

    comba_opbank #(.N(N), .W(W)) u_bank_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .din     (op_b),
        .rd_idx  (idx_b),
        .rd_word (word_b)
    );

    comba_mac #(.N(N), .W(W)) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .mul_en   (mul_en),
        .shift_en (emit_en),
        .op_a     (word_a),
        .op_b     (word_b),
        .lo_word  (lo_word),
        .hi_word  (hi_word),
        .excess   (excess)
    );

    // Result words: cleared on accept, each column written once on emit.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            res_q <= '0;
        end else if (emit_en) begin
            res_q[col*W +: W] <= lo_word;
            if (last_col) res_q[(2*N-1)*W +: W] <= hi_word;
        end
    end

    // Completion pulse after the final emit.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= emit_en && last_col;
    end

    always_comb begin
        done    = done_q;
        product = res_q;
    end

    // R4: done lasts one cycle.
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: done and busy are never high together.
    assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5: busy only rises after a start request.
    assert_busy_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R6: the result does not move while idle without a new start.
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

    // R8: the residue written as the top word fits in one word.
    assert_residue_fits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_en && last_col) |-> (excess == '0));

endmodule

// File: tb/test_comba_mul.sv
// Bench test_comba_mul
// Sweeps corner, walking-word and pseudo-random operands through the
// multiplier (N=4, W=16) and compares against a native wide product.
module test_comba_mul;

    localparam int N   = 4;
    localparam int W   = 16;
    localparam int OW  = N * W;
    localparam int LAT = N * N + 2 * N - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [OW-1:0] op_a = '0;
    logic [OW-1:0] op_b = '0;
    logic          busy;
    logic          done;
    logic [2*OW-1:0] product;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    always #10 clk = ~clk;  // 50 MHz

    comba_mul #(.N(N), .W(W)) i_comba_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_a    (op_a),
        .op_b    (op_b),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] next_rand(input logic [63:0] s);
        logic [63:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    // One multiplication; optionally disturb inputs or restart mid-run.
    task automatic run(input logic [OW-1:0] a, input logic [OW-1:0] b,
                       input bit disturb, input string req);
        logic [127:0] exp = {64'd0, a} * {64'd0, b};
        logic [127:0] held;
        int lat = 0;
        @(negedge clk);
        op_a  = a;
        op_b  = b;
        start = 1'b1;
        @(negedge clk);               // accepting edge has passed
        start = 1'b0;
        check(busy === 1'b1, "R4 busy after start", {127'd0, busy}, 128'd1);
        if (disturb) begin
            op_a = ~a;                // R6: late operand change
            op_b = a ^ b;
        end
        while (!done && lat < LAT + 10) begin
            @(negedge clk);
            lat++;
            if (disturb && lat == 5) start = 1'b1;   // R5: start while busy
            if (disturb && lat == 6) start = 1'b0;
            if (lat == LAT - 1)
                check(done === 1'b0, "R3 early done", {127'd0, done}, 128'd0);
        end
        check(lat == LAT, "R3 latency", 128'(lat), 128'(LAT));
        check(busy === 1'b0, "R4 busy low at done", {127'd0, busy}, 128'd0);
        check(product === exp, req, product, exp);
        held = product;
        @(negedge clk);
        check(done === 1'b0, "R4 done one cycle", {127'd0, done}, 128'd0);
        check(product === held, "R6 product held", product, held);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R1 reset flags",
              {126'd0, busy, done}, 128'd0);
        check(product === '0, "R1 reset product", product, 128'd0);
        rst_n = 1'b1;

        // R7 corners
        run('0, 64'h1234_5678_9ABC_DEF0, 1'b0, "R7 zero operand");
        run({OW{1'b1}}, {OW{1'b1}}, 1'b0, "R7 all ones");
        check(product[127:112] === 16'hFFFF && product[15:0] === 16'h0001,
              "R7 all-ones end words", product, 128'hFFFF_0000_0000_0001);
        run({OW{1'b1}}, 64'd1, 1'b0, "R7 times one");

        // R2 walking single words
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                run(64'hFFFF << (i * W), 64'hFFFF << (j * W), 1'b0, "R2 walking words");
            end
        end

        // R2 pseudo-random sweep, with R5/R6 disturbance on every fourth run
        for (int t = 0; t < 200; t++) begin
            logic [63:0] ra;
            logic [63:0] rb;
            seed = next_rand(seed);
            ra = seed;
            seed = next_rand(seed);
            rb = seed;
            run(ra, rb, (t % 4) == 0, (t % 4) == 0 ? "R5 R6 disturbed run" : "R2 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule